// File: doc/BRIEF.md
# Reference Divider with Selectable Post-Divide Taps

This block turns a reference clock into slower reference pulses for a phase-locked loop. An integer divider counts reference cycles and produces a terminal-count event once every NR cycles. A 3-bit binary counter advances on each terminal count. From that counter the block takes four pulse trains, at NR, 2·NR, 4·NR and 8·NR reference cycles. Two independent 2-bit selects each route one train to an output. One output feeds the main phase detector and the other feeds the auxiliary phase detector.

The block runs when either of two enable inputs is high. When both are low, every counter is held at zero and both outputs stay low. Counting starts again from zero once either enable returns. A new NR value is loaded into the divider only when a period completes, so a period in progress is never cut short or stretched. Each output is registered, and each pulse lasts one reference cycle.

Top module: `ref_tap_divider`

## Requirements
- R1: While rst_ni is low, both pulse outputs are low and all counters are cleared.
- R2: The block counts while en_a_i or en_m_i (or both) is high. With both low for a clock edge, the counters return to zero and both outputs are low in the following cycle. After enable, the first terminal count falls on the NR-th enabled edge.
- R3: With select code 0, an output pulses once every NR reference cycles. The pulse appears in the cycle after the edge on which the divider reaches its terminal count.
- R4: An nr_i value of 0, 1, 2 or 3 divides exactly as an nr_i of 4.
- R5: A change on nr_i during counting takes effect only for the period that starts after the next terminal count. While the block is idle, nr_i is taken on every edge.
- R6: Select code k (0 to 3) gives a pulse at every terminal count whose 1-based index since enable is a multiple of 2^k. This is a period of NR·2^k reference cycles.
- R7: main_sel_i and aux_sel_i act independently. With equal codes, the two outputs are identical.
- R8: Every output pulse is exactly one reference cycle wide.
- R9: A select input may change at any time. It is sampled on the terminal-count edge that produces the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Enable request from the auxiliary path |
| en_m_i | input | 1 | Enable request from the main path |
| nr_i | input | 12 | Integer divide ratio; values below 4 act as 4 |
| main_sel_i | input | 2 | Tap code for the main output (k selects NR·2^k) |
| aux_sel_i | input | 2 | Tap code for the auxiliary output (k selects NR·2^k) |
| main_pulse_o | output | 1 | One-cycle pulse for the main phase detector |
| aux_pulse_o | output | 1 | One-cycle pulse for the auxiliary phase detector |

## Verification
The assertions assume that all inputs are synchronous to clk_i and settle well before each rising edge. They also assume that a reset pulse comes before the first enable. The one-cycle-width property holds only because the effective ratio is never below 4.

The stimulus changes every input on the falling edge and keeps the enables low across reset release. It then walks through enable transitions, out-of-range ratios, ratio changes in the middle of a period, equal and unequal tap codes, and select changes at irregular points inside long periods.

// File: rtl/ref_tap_pkg.sv
package ref_tap_pkg;
  localparam int unsigned NR_W   = 12;
  localparam int unsigned NR_MIN = 4;
  localparam int unsigned POST_W = 3;
endpackage

// File: rtl/ref_tap_prog_div.sv
module ref_tap_prog_div #(
  parameter int unsigned NR_W   = ref_tap_pkg::NR_W,
  parameter int unsigned NR_MIN = ref_tap_pkg::NR_MIN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [NR_W-1:0] nr_i,
  output logic            tc_o
);
  localparam logic [NR_W-1:0] NR_FLOOR = NR_W'(NR_MIN);

  logic [NR_W-1:0] cnt_q;
  logic [NR_W-1:0] nr_q;
  logic [NR_W-1:0] nr_eff;

  assign nr_eff = (nr_i < NR_FLOOR) ? NR_FLOOR : nr_i;
  assign tc_o   = en_i && (cnt_q == nr_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      nr_q  <= NR_FLOOR;
    end else if (!en_i) begin
      cnt_q <= '0;
      nr_q  <= nr_eff;
    end else if (tc_o) begin
      cnt_q <= '0;
      nr_q  <= nr_eff;  // new ratio only at period boundary
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < nr_q);                                                // R3
  AST_RATIO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nr_q >= NR_FLOOR);                                            // R4
  AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tc_o) |=> $stable(nr_q));                           // R5
endmodule

// File: rtl/ref_tap_post.sv
module ref_tap_post #(
  parameter int unsigned POST_W = ref_tap_pkg::POST_W,
  localparam int unsigned N_TAPS = POST_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tc_i,
  output logic [N_TAPS-1:0] tap_o
);
  logic [POST_W-1:0] post_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      post_q <= '0;
    else if (!en_i)   post_q <= '0;
    else if (tc_i)    post_q <= post_q + 1'b1;
  end

  assign tap_o[0] = tc_i;

  for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
    // tap k fires on every 2^k-th terminal count
    assign tap_o[k] = tc_i && (&post_q[k-1:0]);

    AST_TAP_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[k] |-> tap_o[k-1]);                                   // R6
  end

  AST_POST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (post_q == '0));                                    // R2
endmodule

// File: rtl/ref_tap_sel.sv
module ref_tap_sel #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned MUX_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [MUX_W-1:0] taps_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= en_i && taps_i[sel_i];
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);                                        // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_o);                                          // R2
endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider #(
  parameter int unsigned NR_W   = ref_tap_pkg::NR_W,
  parameter int unsigned NR_MIN = ref_tap_pkg::NR_MIN,
  parameter int unsigned POST_W = ref_tap_pkg::POST_W,
  localparam int unsigned N_TAPS = POST_W + 1,
  localparam int unsigned SEL_W  = $clog2(N_TAPS),
  localparam int unsigned MUX_W  = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_a_i,
  input  logic             en_m_i,
  input  logic [NR_W-1:0]  nr_i,
  input  logic [SEL_W-1:0] main_sel_i,
  input  logic [SEL_W-1:0] aux_sel_i,
  output logic             main_pulse_o,
  output logic             aux_pulse_o
);
  logic              en;
  logic              tc;
  logic [N_TAPS-1:0] taps;
  logic [MUX_W-1:0]  taps_pad;

  assign en       = en_a_i | en_m_i;
  assign taps_pad = MUX_W'(taps);

  ref_tap_prog_div #(.NR_W(NR_W), .NR_MIN(NR_MIN)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .nr_i  (nr_i),
    .tc_o  (tc)
  );

  ref_tap_post #(.POST_W(POST_W)) u_post (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tc_i  (tc),
    .tap_o (taps)
  );

  ref_tap_sel #(.SEL_W(SEL_W)) u_sel_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .taps_i (taps_pad),
    .sel_i  (main_sel_i),
    .pulse_o(main_pulse_o)
  );

  ref_tap_sel #(.SEL_W(SEL_W)) u_sel_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .taps_i (taps_pad),
    .sel_i  (aux_sel_i),
    .pulse_o(aux_pulse_o)
  );

  AST_SAME_CODE_SAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_sel_i == aux_sel_i) |=> (main_pulse_o == aux_pulse_o)); // R7
  AST_TAP_PULSE_LOW_IN_RESET: assert property (@(posedge clk_i)
    !rst_ni |-> (!main_pulse_o && !aux_pulse_o));                 // R1
endmodule

// File: tb/tb_ref_tap_divider.sv
module tb_ref_tap_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_a = 1'b0;
  logic        en_m = 1'b0;
  logic [11:0] nr = 12'd5;
  logic [1:0]  main_sel = 2'd0;
  logic [1:0]  aux_sel = 2'd0;
  logic        main_p;
  logic        aux_p;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_cnt = 0;
  int m_nr = 4;
  int m_ticks = 0;
  bit exp_main = 1'b0;
  bit exp_aux = 1'b0;
  bit prev_main = 1'b0;
  bit prev_aux = 1'b0;

  always #5 clk = ~clk;

  ref_tap_divider dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_a_i      (en_a),
    .en_m_i      (en_m),
    .nr_i        (nr),
    .main_sel_i  (main_sel),
    .aux_sel_i   (aux_sel),
    .main_pulse_o(main_p),
    .aux_pulse_o (aux_p)
  );

  function automatic int eff_ratio(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_nr = 4; m_ticks = 0; exp_main = 0; exp_aux = 0;
    end else if (!(en_a || en_m)) begin
      m_cnt = 0; m_ticks = 0; m_nr = eff_ratio(int'(nr));
      exp_main = 0; exp_aux = 0;
    end else begin
      bit fire;
      fire = (m_cnt == m_nr - 1);
      exp_main = fire && (((m_ticks + 1) % (1 << main_sel)) == 0);
      exp_aux  = fire && (((m_ticks + 1) % (1 << aux_sel)) == 0);
      if (fire) begin
        m_cnt = 0; m_ticks = m_ticks + 1; m_nr = eff_ratio(int'(nr));
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 2;
      if (main_p !== exp_main) begin
        fails++;
        $display("FAIL %s main_pulse_o: actual %b expected %b at cycle %0d", tag, main_p, exp_main, cycles);
      end
      if (aux_p !== exp_aux) begin
        fails++;
        $display("FAIL %s aux_pulse_o: actual %b expected %b at cycle %0d", tag, aux_p, exp_aux, cycles);
      end
      if (prev_main) begin
        checks++;
        if (main_p) begin
          fails++;
          $display("FAIL R8 main pulse width: actual 2+ cycles expected 1");
        end
      end
      if (prev_aux) begin
        checks++;
        if (aux_p) begin
          fails++;
          $display("FAIL R8 aux pulse width: actual 2+ cycles expected 1");
        end
      end
      prev_main = main_p;
      prev_aux  = aux_p;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    run(3);
    checks += 2;
    if (main_p !== 1'b0) begin fails++; $display("FAIL R1 main in reset: actual %b expected 0", main_p); end
    if (aux_p !== 1'b0) begin fails++; $display("FAIL R1 aux in reset: actual %b expected 0", aux_p); end
    rst_n = 1'b1;
    tag = "R2"; run(5);

    // R3/R6: basic division, main tap 0, aux tap 1
    tag = "R3"; nr = 12'd5; main_sel = 2'd0; aux_sel = 2'd1; en_m = 1'b1;
    run(200);

    // R2: idle then restart on the other enable, then both
    tag = "R2"; en_m = 1'b0; run(7);
    en_a = 1'b1; run(60);
    en_m = 1'b1; run(40);
    en_a = 1'b0; en_m = 1'b0; run(1);

    // R4: ratios below the floor
    tag = "R4"; nr = 12'd0; main_sel = 2'd0; aux_sel = 2'd3; en_a = 1'b1;
    run(80);
    nr = 12'd3; run(40);
    nr = 12'd1; run(40);

    // R5: ratio changes mid-period
    tag = "R5"; nr = 12'd9; run(3); nr = 12'd6; run(31);
    nr = 12'd40; run(17); nr = 12'd13; main_sel = 2'd2; aux_sel = 2'd3; run(300);
    en_a = 1'b0; nr = 12'd21; run(2); nr = 12'd7; en_m = 1'b1; run(120);

    // R7: identical codes, then differing
    tag = "R7"; nr = 12'd11; main_sel = 2'd1; aux_sel = 2'd1; run(200);
    main_sel = 2'd3; aux_sel = 2'd0; run(200);

    // R9: select changes at irregular points
    tag = "R9"; nr = 12'd4;
    for (int i = 0; i < 60; i++) begin
      main_sel = 2'(i * 3 + 1);
      aux_sel  = 2'(i * 5 + 2);
      run(7 + (i % 6));
    end

    // R6: long periods on the coarse taps
    tag = "R6"; en_m = 1'b0; en_a = 1'b0; run(1);
    nr = 12'd300; main_sel = 2'd3; aux_sel = 2'd2; en_a = 1'b1; run(5000);
    nr = 12'd4095; main_sel = 2'd0; aux_sel = 2'd1; run(9000);

    tag = "R2"; en_a = 1'b0; run(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule